// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns one host packet into the byte stream for one Ethernet frame. The host sends the header bytes (destination address, source address, length/type) and then the payload bytes, one byte per cycle, over a valid/ready stream that marks its final byte. The block puts a preamble and start delimiter in front of them. If the payload is short it adds zero padding, and it closes the frame with a CRC-32 frame check sequence. The result leaves on a byte stream with valid, ready and a last marker, ready for a serializer.

A single-cycle start pulse begins each frame. At that pulse the block samples three options: omit the preamble, omit the check sequence (the host then supplies its own), and pad short payloads. The options hold until the last output byte has been taken. If the host sends more header and payload than a maximum-size frame allows, the block cuts the frame at the limit, still closes it with a check sequence and last, and raises an oversize flag. It then discards the rest of that packet. Backpressure on the output stalls every internal counter, so no byte is lost or repeated.

Top module: `eth_tx_framer`

## Requirements
- R1: With the preamble enabled, the first eight output bytes are 0x55 seven times and then 0xD5. The host bytes follow in the order they were supplied.
- R2: With the no-preamble option set at the start pulse, the first output byte is the first host byte.
- R3: With padding enabled and fewer than 60 host bytes (header plus data), 0x00 bytes follow the host bytes until 60 bytes have been sent after the preamble. With padding disabled, no pad byte is added.
- R4: Unless suppressed, four check-sequence bytes follow the host bytes and any padding. They are the complement of CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF) over every byte after the preamble, sent least significant byte first. The last marker is set on the fourth of them only.
- R5: With the no-check-sequence option set, nothing is appended, and the last marker is set on the final host byte (or on the final pad byte when padding applies).
- R6: Packets with 60 or more host bytes get no padding. No frame carries more than 8 + 1514 + 4 bytes.
- R7: If a packet has more than 1514 host bytes, the frame holds only the first 1514 of them and is closed with its check sequence. `oversize_o` then stays high until the next accepted start, and the remaining host bytes up to the packet's last marker are accepted and discarded.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output byte and last marker hold steady. Every byte of the frame appears exactly once.
- R9: `in_ready_o` is high only while the block is busy with a frame. A start pulse while busy is ignored and does not change the options of the frame in progress.
- R10: After reset `out_valid_o`, `in_ready_o`, `busy_o` and `oversize_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle frame start pulse, taken only when idle |
| opt_no_pre_i | input | 1 | Omit the preamble, sampled at start |
| opt_no_fcs_i | input | 1 | Omit the check sequence, sampled at start |
| opt_pad_i | input | 1 | Pad short payloads, sampled at start |
| in_data_i | input | 8 | Host byte |
| in_valid_i | input | 1 | Host byte valid |
| in_last_i | input | 1 | Host byte is the final byte of the packet |
| in_ready_o | output | 1 | Block accepts the host byte |
| out_data_o | output | 8 | Frame byte |
| out_valid_o | output | 1 | Frame byte valid |
| out_last_o | output | 1 | Frame byte is the final byte of the frame |
| out_ready_i | input | 1 | Downstream accepts the frame byte |
| busy_o | output | 1 | A frame is in progress |
| oversize_o | output | 1 | The last frame was truncated |

## Verification
The assertions check four properties on every cycle: the output holds steady under backpressure, the host side is idle outside a frame, the byte count of each frame stays within the limit, and the oversize flag stays set. A closed frame must also be followed by a cycle with no output. Byte values need the bench's scenarios, which compare whole frames against a model built from the requirements. That covers the preamble pattern, padding, the CRC bytes and their order, truncation with the discarded tail, and the options staying fixed when a start pulse arrives during a frame.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

   localparam logic [7:0]  PRE_BYTE  = 8'h55;
   localparam logic [7:0]  SFD_BYTE  = 8'hD5;
   localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
   localparam logic [31:0] CRC_RPOLY = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_BODY,
      ST_PAD,
      ST_FCS,
      ST_TAIL,
      ST_DRAIN
   } tx_state_e;

   typedef struct packed {
      logic no_pre;
      logic no_fcs;
      logic pad;
   } tx_opts_t;

   // one byte of reflected CRC-32, LSB of the byte first
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'd0, d};
      for (int b = 0; b < 8; b++) begin
         r = r[0] ? ((r >> 1) ^ CRC_RPOLY) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
   import eth_tx_pkg::*;
#(
   parameter int CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             upd_i,
   input  logic [7:0]       data_i,
   output logic [CRC_W-1:0] fcs_o
);
   logic [CRC_W-1:0] crc_q;

   generate
      if (CRC_W != 32) begin : g_bad_width
         $error("eth_tx_crc supports only a 32-bit check sequence");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         crc_q <= CRC_SEED;
      end else if (upd_i) begin
         crc_q <= crc32_step(crc_q, data_i);
      end
   end

   assign fcs_o = ~crc_q;

endmodule

// File: rtl/eth_tx_outreg.sv
module eth_tx_outreg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          last_i,
   input  logic          ready_i,
   output logic          adv_o,
   output logic          valid_o,
   output logic [DW-1:0] data_o,
   output logic          last_o
);
   assign adv_o = !valid_o || ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         last_o  <= 1'b0;
      end else if (adv_o) begin
         valid_o <= load_i;
         if (load_i) begin
            data_o <= data_i;
            last_o <= last_i;
         end else begin
            last_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN  = 8,
   parameter int HDR_LEN  = 14,
   parameter int MIN_DATA = 46,
   parameter int MAX_BODY = 1514,
   parameter int FCS_LEN  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  tx_opts_t    opts_i,
   input  logic [7:0]  in_data_i,
   input  logic        in_valid_i,
   input  logic        in_last_i,
   output logic        in_ready_o,
   input  logic        adv_i,
   input  logic [31:0] fcs_i,
   output logic        load_o,
   output logic [7:0]  ld_data_o,
   output logic        ld_last_o,
   output logic        crc_init_o,
   output logic        crc_upd_o,
   output logic        busy_o,
   output logic        oversize_o
);
   localparam int MIN_BODY = HDR_LEN + MIN_DATA;
   localparam int CW       = $clog2(MAX_BODY + 1);
   localparam int IW       = $clog2(PRE_LEN + FCS_LEN);

   generate
      if (PRE_LEN < 2) begin : g_bad_pre
         $error("PRE_LEN must cover at least one preamble byte and the delimiter");
      end
      if (MIN_BODY > MAX_BODY) begin : g_bad_min
         $error("minimum body exceeds maximum body");
      end
      if (FCS_LEN != 4) begin : g_bad_fcs
         $error("check sequence must be 4 bytes");
      end
   endgenerate

   tx_state_e       state_q, state_d;
   tx_opts_t        opts_q;
   logic [CW-1:0]   bcnt_q, bcnt_nx;
   logic [IW-1:0]   icnt_q;
   logic            ovs_q, drain_q;
   logic            in_hs, body_full, need_pad, trunc;
   logic [31:0]     fcs_sh;

   assign in_ready_o = ((state_q == ST_BODY) && adv_i) || (state_q == ST_DRAIN);
   assign in_hs      = in_valid_i && in_ready_o;
   assign bcnt_nx    = bcnt_q + 1'b1;
   assign body_full  = (bcnt_q == CW'(MAX_BODY - 1));
   assign need_pad   = opts_q.pad && (bcnt_nx < CW'(MIN_BODY));
   assign trunc      = (state_q == ST_BODY) && in_hs && body_full && !in_last_i;
   assign fcs_sh     = fcs_i >> {icnt_q, 3'b000};
   assign busy_o     = (state_q != ST_IDLE);
   assign oversize_o = ovs_q;

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      ld_data_o  = 8'h00;
      ld_last_o  = 1'b0;
      crc_init_o = 1'b0;
      crc_upd_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               crc_init_o = 1'b1;
               state_d    = opts_i.no_pre ? ST_BODY : ST_PRE;
            end
         end
         ST_PRE: begin
            if (adv_i) begin
               load_o    = 1'b1;
               ld_data_o = (icnt_q == IW'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
               if (icnt_q == IW'(PRE_LEN - 1)) state_d = ST_BODY;
            end
         end
         ST_BODY: begin
            if (in_hs) begin
               load_o    = 1'b1;
               ld_data_o = in_data_i;
               crc_upd_o = 1'b1;
               if (in_last_i || body_full) begin
                  if (need_pad) begin
                     state_d = ST_PAD;
                  end else if (!opts_q.no_fcs) begin
                     state_d = ST_FCS;
                  end else begin
                     ld_last_o = 1'b1;
                     state_d   = ST_TAIL;
                  end
               end
            end
         end
         ST_PAD: begin
            if (adv_i) begin
               load_o    = 1'b1;
               crc_upd_o = 1'b1;
               if (bcnt_nx == CW'(MIN_BODY)) begin
                  if (opts_q.no_fcs) begin
                     ld_last_o = 1'b1;
                     state_d   = ST_TAIL;
                  end else begin
                     state_d   = ST_FCS;
                  end
               end
            end
         end
         ST_FCS: begin
            if (adv_i) begin
               load_o    = 1'b1;
               ld_data_o = fcs_sh[7:0];
               if (icnt_q == IW'(FCS_LEN - 1)) begin
                  ld_last_o = 1'b1;
                  state_d   = ST_TAIL;
               end
            end
         end
         ST_TAIL: begin
            if (adv_i) state_d = drain_q ? ST_DRAIN : ST_IDLE;
         end
         ST_DRAIN: begin
            if (in_hs && in_last_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         opts_q  <= '0;
         bcnt_q  <= '0;
         icnt_q  <= '0;
         ovs_q   <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            opts_q  <= opts_i;
            bcnt_q  <= '0;
            ovs_q   <= 1'b0;
            drain_q <= 1'b0;
         end
         if (load_o && (state_q == ST_BODY || state_q == ST_PAD)) bcnt_q <= bcnt_nx;
         if (state_d != state_q) begin
            icnt_q <= '0;
         end else if (load_o && (state_q == ST_PRE || state_q == ST_FCS)) begin
            icnt_q <= icnt_q + 1'b1;
         end
         if (trunc) begin
            ovs_q   <= 1'b1;
            drain_q <= 1'b1;
         end
         if (state_q == ST_DRAIN && state_d == ST_IDLE) drain_q <= 1'b0;
      end
   end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN  = 8,
   parameter int HDR_LEN  = 14,
   parameter int MIN_DATA = 46,
   parameter int MAX_BODY = 1514,
   parameter int FCS_LEN  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       opt_no_pre_i,
   input  logic       opt_no_fcs_i,
   input  logic       opt_pad_i,
   input  logic [7:0] in_data_i,
   input  logic       in_valid_i,
   input  logic       in_last_i,
   output logic       in_ready_o,
   output logic [7:0] out_data_o,
   output logic       out_valid_o,
   output logic       out_last_o,
   input  logic       out_ready_i,
   output logic       busy_o,
   output logic       oversize_o
);
   tx_opts_t    opts;
   logic        adv, load, ld_last, crc_init, crc_upd;
   logic [7:0]  ld_data;
   logic [31:0] fcs;

   assign opts = '{no_pre: opt_no_pre_i, no_fcs: opt_no_fcs_i, pad: opt_pad_i};

   eth_tx_ctrl #(
      .PRE_LEN (PRE_LEN),
      .HDR_LEN (HDR_LEN),
      .MIN_DATA(MIN_DATA),
      .MAX_BODY(MAX_BODY),
      .FCS_LEN (FCS_LEN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .opts_i    (opts),
      .in_data_i (in_data_i),
      .in_valid_i(in_valid_i),
      .in_last_i (in_last_i),
      .in_ready_o(in_ready_o),
      .adv_i     (adv),
      .fcs_i     (fcs),
      .load_o    (load),
      .ld_data_o (ld_data),
      .ld_last_o (ld_last),
      .crc_init_o(crc_init),
      .crc_upd_o (crc_upd),
      .busy_o    (busy_o),
      .oversize_o(oversize_o)
   );

   eth_tx_crc #(.CRC_W(32)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init_i(crc_init),
      .upd_i (crc_upd),
      .data_i(ld_data),
      .fcs_o (fcs)
   );

   eth_tx_outreg #(.DW(8)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .data_i (ld_data),
      .last_i (ld_last),
      .ready_i(out_ready_i),
      .adv_o  (adv),
      .valid_o(out_valid_o),
      .data_o (out_data_o),
      .last_o (out_last_o)
   );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
   parameter int PRE_LEN  = 8,
   parameter int MAX_BODY = 1514,
   parameter int FCS_LEN  = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       in_ready_o,
   input logic [7:0] out_data_o,
   input logic       out_valid_o,
   input logic       out_last_o,
   input logic       out_ready_i,
   input logic       busy_o,
   input logic       oversize_o
);
   localparam int LIMIT = PRE_LEN + MAX_BODY + FCS_LEN;
   localparam int LW    = $clog2(LIMIT + 2);

   logic          ohs;
   logic [LW-1:0] fcnt_q;

   assign ohs = out_valid_o && out_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt_q <= '0;
      end else if (ohs) begin
         fcnt_q <= out_last_o ? '0 : fcnt_q + 1'b1;
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

   assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> busy_o);

   assert_gap_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ohs && out_last_o) |=> !out_valid_o);

   assert_len_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ohs |-> (fcnt_q < LW'(LIMIT)));

   assert_ovs_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oversize_o && !(start_i && !busy_o)) |=> oversize_o);

endmodule

bind eth_tx_framer eth_tx_framer_chk #(
   .PRE_LEN (PRE_LEN),
   .MAX_BODY(MAX_BODY),
   .FCS_LEN (FCS_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .in_ready_o (in_ready_o),
   .out_data_o (out_data_o),
   .out_valid_o(out_valid_o),
   .out_last_o (out_last_o),
   .out_ready_i(out_ready_i),
   .busy_o     (busy_o),
   .oversize_o (oversize_o)
);

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       opt_no_pre_i = 1'b0;
   logic       opt_no_fcs_i = 1'b0;
   logic       opt_pad_i = 1'b0;
   logic [7:0] in_data_i = 8'h00;
   logic       in_valid_i = 1'b0;
   logic       in_last_i = 1'b0;
   logic       in_ready_o;
   logic [7:0] out_data_o;
   logic       out_valid_o;
   logic       out_last_o;
   logic       out_ready_i = 1'b0;
   logic       busy_o;
   logic       oversize_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] src [0:1599];
   logic [7:0] got [0:1999];
   logic [7:0] exp_b [0:1999];

   always #5 clk = ~clk;

   eth_tx_framer dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .opt_no_pre_i(opt_no_pre_i), .opt_no_fcs_i(opt_no_fcs_i), .opt_pad_i(opt_pad_i),
      .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
      .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
      .out_last_o(out_last_o), .out_ready_i(out_ready_i), .busy_o(busy_o),
      .oversize_o(oversize_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'd0, d};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic test_reset();
      @(negedge clk);
      check(out_valid_o == 1'b0 && in_ready_o == 1'b0 && busy_o == 1'b0 && oversize_o == 1'b0,
            "R10 reset outputs low", {out_valid_o, in_ready_o, busy_o, oversize_o}, 0);
   endtask

   // drives one packet and collects one frame, then compares with the model
   task automatic run_frame(input string tag, input int len, input bit no_pre, input bit no_fcs,
                            input bit pad, input bit stall, input bit mid_start, input bit exp_ovs);
      int ip = 0, gn = 0, lastpos = -1, nlast = 0, en = 0, blen, mism = 0, cyc = 0;
      bit done = 0;
      logic [31:0] crc = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) src[i] = 8'((i * 37 + len) ^ 8'h5A);
      // expected frame
      if (!no_pre) begin
         for (int i = 0; i < 7; i++) exp_b[en++] = 8'h55;
         exp_b[en++] = 8'hD5;
      end
      blen = (len > 1514) ? 1514 : len;
      for (int i = 0; i < blen; i++) begin
         exp_b[en++] = src[i];
         crc = crc_upd(crc, src[i]);
      end
      if (pad) begin
         for (int i = blen; i < 60; i++) begin
            exp_b[en++] = 8'h00;
            crc = crc_upd(crc, 8'h00);
         end
      end
      if (!no_fcs) begin
         crc = ~crc;
         for (int i = 0; i < 4; i++) exp_b[en++] = crc[8*i +: 8];
      end
      // start pulse
      @(negedge clk);
      start_i = 1'b1; opt_no_pre_i = no_pre; opt_no_fcs_i = no_fcs; opt_pad_i = pad;
      @(negedge clk);
      start_i = 1'b0;
      // options change after start must not matter
      opt_no_pre_i = ~no_pre; opt_no_fcs_i = ~no_fcs; opt_pad_i = ~pad;
      while (!(done && ip == len) && cyc < 6000) begin
         start_i     = (mid_start && cyc == 10);
         out_ready_i = stall ? (cyc % 3 != 2) : 1'b1;
         in_valid_i  = (ip < len) && (stall ? (cyc % 4 != 1) : 1'b1);
         in_data_i   = (ip < len) ? src[ip] : 8'h00;
         in_last_i   = (ip == len - 1);
         #1;
         if (in_valid_i && in_ready_o) ip++;
         if (out_valid_o && out_ready_i) begin
            if (gn < 2000) got[gn] = out_data_o;
            if (out_last_o) begin
               nlast++; lastpos = gn; done = 1;
            end
            gn++;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
      check(cyc < 6000, {tag, " frame completes"}, cyc, 6000);
      check(gn == en, {tag, " frame length"}, gn, en);
      for (int i = 0; i < en && i < gn; i++) if (got[i] !== exp_b[i]) mism++;
      check(mism == 0, {tag, " byte content"}, mism, 0);
      check(nlast == 1 && lastpos == gn - 1, {tag, " last on final byte"}, lastpos, gn - 1);
      check(ip == len, {tag, " all host bytes consumed"}, ip, len);
      check(oversize_o == exp_ovs, {tag, " oversize flag"}, oversize_o, exp_ovs);
      @(negedge clk);
      check(busy_o == 1'b0, {tag, " idle after frame"}, busy_o, 0);
      // host offers a byte while idle: must not be taken, no output appears (R9)
      in_valid_i = 1'b1; in_data_i = 8'hEE; in_last_i = 1'b1;
      #1;
      check(in_ready_o == 1'b0, {tag, " R9 no ready when idle"}, in_ready_o, 0);
      @(negedge clk);
      check(out_valid_o == 1'b0, {tag, " R9 no output when idle"}, out_valid_o, 0);
      in_valid_i = 1'b0; in_last_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      run_frame("R1 R4 R6 full frame",        64, 0, 0, 1, 0, 0, 0);
      run_frame("R3 R4 padded short frame",   20, 0, 0, 1, 0, 0, 0);
      run_frame("R3 short frame no pad",      20, 0, 0, 0, 0, 0, 0);
      run_frame("R2 no preamble",             40, 1, 0, 0, 0, 0, 0);
      run_frame("R5 no check sequence",       30, 0, 1, 0, 0, 0, 0);
      run_frame("R5 pad without check seq",   17, 0, 1, 1, 0, 0, 0);
      run_frame("R8 backpressure padded",     40, 0, 0, 1, 1, 0, 0);
      run_frame("R8 backpressure long",      200, 1, 0, 1, 1, 0, 0);
      run_frame("R9 start while busy",        50, 0, 0, 1, 0, 1, 0);
      run_frame("R6 max size frame",        1514, 0, 0, 1, 0, 0, 0);
      run_frame("R7 oversize truncation",   1525, 0, 0, 1, 0, 0, 1);
      run_frame("R7 flag clears next start",  64, 0, 0, 0, 0, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule